// File: doc/BRIEF.md
# DMA Interrupt Flag Register

This block is the interrupt control word of a multi-channel DMA controller. It stores a small set of plain fields that software writes directly: six general bits, a bus-error force bit, one interrupt enable per channel and a master enable. Next to those fields it keeps one completion flag per channel. Two things change a flag. A channel's completion pulse sets the flag when that channel is enabled. A CPU write with a 1 in the flag's position clears it.

The top bit of the word is a summary flag. The block does not store it: it derives that bit from the current contents on every cycle. The bit is 1 when the force bit is set, or when the master enable is set and any channel flag is set. When the summary bit changes from 0 to 1, the block raises a single-cycle request toward the system interrupt controller. Whether the rise comes from a CPU write or from a channel event makes no difference. The whole word can be read at any time on a parallel output.

Top module: `dma_irq_ctl`

## Requirements
- R1: While reset is asserted, every bit of the read word is 0 and the interrupt pulse is low.
- R2: A write stores its data bits 0-5 and 15-23 exactly, that is, the bits of mask 0x00FF803F. Bit 15 is the force bit, bits 16-22 are the enables for channels 0-6, and bit 23 is the master enable.
- R3: Bits 6-14 of the read word are always 0, whatever is written.
- R4: A write with a 1 in bit 24+n clears the flag of channel n. A 0 in that position leaves the flag unchanged.
- R5: A completion pulse on channel n sets flag bit 24+n on the next clock edge when enable bit 16+n is set. When that enable is clear, the pulse leaves the word unchanged.
- R6: When a completion pulse sets a flag in the same cycle that a write clears it, the flag ends up set.
- R7: Bit 31 reads 1 exactly when bit 15 is set, or when bit 23 is set together with at least one of bits 24-30. The bit follows both write updates and completion events.
- R8: The interrupt pulse is high for exactly one cycle, in the first cycle that bit 31 reads 1 after reading 0. It stays low for as long as bit 31 stays 1, and it fires again after bit 31 has fallen and risen once more.
- R9: A write can never set a channel flag: bits 24-30 are cleared or kept, never loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_data | input | 32 | CPU write data |
| chan_done | input | 7 | Completion pulses, one bit per channel |
| rd_data | output | 32 | Current register contents, including the derived bit 31 |
| irq_pulse | output | 1 | One-cycle interrupt request on a rising bit 31 |

## Verification
Writes and completion events take effect on the clock edge that samples them. Because bit 31 is derived from the stored contents without a register in between, the read word and bit 31 are valid in the cycle after that edge. The interrupt pulse is high in that same cycle and low again one cycle later. The bench applies every stimulus at a falling edge and holds it across one rising edge. It then compares the read word and the pulse at the next falling edge, and for the pulse cases it also checks that the pulse is low one cycle after that. The clear-versus-set collision case is exercised by presenting the write and the channel pulse together across the same edge.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  // Channel count and word layout. The bit positions are decoded by software
  // and by the interrupt routing, so they are fixed.
  localparam int unsigned DIRQ_CH       = 7;
  localparam int unsigned DIRQ_WORD_W   = 32;
  localparam int unsigned DIRQ_AUX_W    = 6;
  localparam int unsigned DIRQ_FORCE    = 15;
  localparam int unsigned DIRQ_EN_LSB   = 16;
  localparam int unsigned DIRQ_MEN      = 23;
  localparam int unsigned DIRQ_FLG_LSB  = 24;
  localparam int unsigned DIRQ_SUM      = 31;
  localparam int unsigned DIRQ_GAP_LSB  = DIRQ_AUX_W;
  localparam int unsigned DIRQ_GAP_MSB  = DIRQ_FORCE - 1;

  typedef struct packed {
    logic [DIRQ_CH-1:0]    en;
    logic                  men;
    logic                  force_err;
    logic [DIRQ_AUX_W-1:0] aux;
  } dirq_fields_t;
endpackage

// File: rtl/dirq_field_reg.sv
module dirq_field_reg
  import dirq_pkg::*;
#(
  parameter int unsigned NUM_CH = DIRQ_CH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [DIRQ_WORD_W-1:0] wr_data,
  output logic [NUM_CH-1:0]      en_q,
  output logic                   men_q,
  output logic                   force_q,
  output logic [DIRQ_AUX_W-1:0]  aux_q
);
  logic [NUM_CH-1:0]     en_d;
  logic                  men_d;
  logic                  force_d;
  logic [DIRQ_AUX_W-1:0] aux_d;

  // Next state: plain fields load on a write and hold otherwise.
  always_comb begin
    en_d    = en_q;
    men_d   = men_q;
    force_d = force_q;
    aux_d   = aux_q;
    if (wr_en) begin
      en_d    = wr_data[DIRQ_EN_LSB +: NUM_CH];
      men_d   = wr_data[DIRQ_MEN];
      force_d = wr_data[DIRQ_FORCE];
      aux_d   = wr_data[DIRQ_AUX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      men_q   <= 1'b0;
      force_q <= 1'b0;
      aux_q   <= '0;
    end else if (wr_en) begin
      en_q    <= en_d;
      men_q   <= men_d;
      force_q <= force_d;
      aux_q   <= aux_d;
    end
  end
endmodule

// File: rtl/dirq_flag_bank.sv
module dirq_flag_bank
  import dirq_pkg::*;
#(
  parameter int unsigned NUM_CH = DIRQ_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NUM_CH-1:0] clr_bits,
  input  logic [NUM_CH-1:0] chan_done,
  input  logic [NUM_CH-1:0] en_q,
  output logic [NUM_CH-1:0] flag_q
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_flag
    logic set_c;
    logic clr_c;
    logic flag_d;
    logic upd_c;

    always_comb begin
      set_c  = chan_done[g] & en_q[g];
      clr_c  = wr_en & clr_bits[g];
      upd_c  = set_c | clr_c;
      // A set in the same cycle as a clear wins.
      flag_d = set_c ? 1'b1 : (clr_c ? 1'b0 : flag_q[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q[g] <= 1'b0;
      else if (upd_c) flag_q[g] <= flag_d;
    end
  end
endmodule

// File: rtl/dirq_master.sv
module dirq_master
  import dirq_pkg::*;
#(
  parameter int unsigned NUM_CH = DIRQ_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_q,
  input  logic              men_q,
  input  logic [NUM_CH-1:0] flag_q,
  output logic              sum_flag,
  output logic              irq_pulse
);
  logic sum_prev_q;
  logic sum_prev_d;

  always_comb begin
    sum_flag   = force_q | (men_q & (|flag_q));
    sum_prev_d = sum_flag;
    irq_pulse  = sum_flag & ~sum_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_prev_q <= 1'b0;
    else        sum_prev_q <= sum_prev_d;
  end
endmodule

// File: rtl/dma_irq_ctl.sv
module dma_irq_ctl
  import dirq_pkg::*;
#(
  parameter int unsigned NUM_CH = DIRQ_CH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [DIRQ_WORD_W-1:0] wr_data,
  input  logic [NUM_CH-1:0]      chan_done,
  output logic [DIRQ_WORD_W-1:0] rd_data,
  output logic                   irq_pulse
);
  logic [NUM_CH-1:0]     en_q;
  logic                  men_q;
  logic                  force_q;
  logic [DIRQ_AUX_W-1:0] aux_q;
  logic [NUM_CH-1:0]     flag_q;
  logic                  sum_flag;
  logic                  unused_gap;

  assign unused_gap = ^wr_data[DIRQ_GAP_MSB:DIRQ_GAP_LSB] ^ wr_data[DIRQ_SUM];

  dirq_field_reg #(.NUM_CH(NUM_CH)) u_fields (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .en_q(en_q), .men_q(men_q), .force_q(force_q), .aux_q(aux_q)
  );

  dirq_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .clr_bits(wr_data[DIRQ_FLG_LSB +: NUM_CH]),
    .chan_done(chan_done), .en_q(en_q), .flag_q(flag_q)
  );

  dirq_master #(.NUM_CH(NUM_CH)) u_master (
    .clk(clk), .rst_n(rst_n), .force_q(force_q), .men_q(men_q),
    .flag_q(flag_q), .sum_flag(sum_flag), .irq_pulse(irq_pulse)
  );

  always_comb begin
    rd_data                           = '0;
    rd_data[DIRQ_AUX_W-1:0]           = aux_q;
    rd_data[DIRQ_FORCE]               = force_q;
    rd_data[DIRQ_EN_LSB +: NUM_CH]    = en_q;
    rd_data[DIRQ_MEN]                 = men_q;
    rd_data[DIRQ_FLG_LSB +: NUM_CH]   = flag_q;
    rd_data[DIRQ_SUM]                 = sum_flag;
  end
endmodule

// File: rtl/dirq_chk.sv
module dirq_chk
  import dirq_pkg::*;
#(
  parameter int unsigned NUM_CH = DIRQ_CH
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [DIRQ_WORD_W-1:0] wr_data,
  input logic [NUM_CH-1:0]      chan_done,
  input logic [DIRQ_WORD_W-1:0] rd_data,
  input logic                   irq_pulse
);
  logic [NUM_CH-1:0] set_now;
  logic [NUM_CH-1:0] flg_now;
  assign set_now = chan_done & rd_data[DIRQ_EN_LSB +: NUM_CH];
  assign flg_now = rd_data[DIRQ_FLG_LSB +: NUM_CH];

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (rd_data == '0 && !irq_pulse);
    end
  end

  assert_plain_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[DIRQ_MEN:DIRQ_FORCE] == $past(wr_data[DIRQ_MEN:DIRQ_FORCE]))
           && (rd_data[DIRQ_AUX_W-1:0] == $past(wr_data[DIRQ_AUX_W-1:0])));

  assert_gap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DIRQ_GAP_MSB:DIRQ_GAP_LSB] == '0);

  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((flg_now & $past(wr_data[DIRQ_FLG_LSB +: NUM_CH] & ~set_now)) == '0));

  // Also covers R6: a set is seen even when a clear is presented with it.
  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_now) |=> ((flg_now & $past(set_now)) == $past(set_now)));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(|chan_done)) |=> $stable(rd_data));

  assert_pulse_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (rd_data[DIRQ_SUM] && !$past(rd_data[DIRQ_SUM])));

  assert_rise_gives_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[DIRQ_SUM]) |-> irq_pulse);

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  assert_no_write_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|chan_done) |=> ((flg_now & ~$past(flg_now)) == '0));
endmodule

bind dma_irq_ctl dirq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .chan_done(chan_done), .rd_data(rd_data), .irq_pulse(irq_pulse)
);

// File: tb/dma_irq_ctl_tb.sv
`timescale 1ns/1ps
module dma_irq_ctl_tb;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [6:0]  chan_done;
  logic [31:0] rd_data;
  logic        irq_pulse;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  dma_irq_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .chan_done(chan_done), .rd_data(rd_data), .irq_pulse(irq_pulse)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {write data, expected read word, expected pulse}, applied in order.
  localparam logic [64:0] VEC [0:7] = '{
    {32'hFFFF_FFFF, 32'h80FF_803F, 1'b1},
    {32'h0000_0000, 32'h0000_0000, 1'b0},
    {32'h0080_0015, 32'h0080_0015, 1'b0},
    {32'h0000_8000, 32'h8000_8000, 1'b1},
    {32'h0000_8000, 32'h8000_8000, 1'b0},
    {32'h0000_7FC0, 32'h0000_0000, 1'b0},
    {32'h7F7F_0000, 32'h007F_0000, 1'b0},
    {32'h00FF_002A, 32'h00FF_002A, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] exp_rd, input logic exp_irq);
    n_checks++;
    if (rd_data !== exp_rd || irq_pulse !== exp_irq) begin
      n_errors++;
      $display("FAIL %s: rd=%h irq=%b expected rd=%h irq=%b", req, rd_data, irq_pulse, exp_rd, exp_irq);
    end
  endtask

  // Drive at a falling edge, hold across one rising edge, release at the next falling edge.
  task automatic step(input logic we, input logic [31:0] d, input logic [6:0] done);
    wr_en = we; wr_data = d; chan_done = done;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; chan_done = '0;
  endtask

  task automatic idle_check(input string req, input logic [31:0] exp_rd);
    @(negedge clk);
    check(req, exp_rd, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; chan_done = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", 32'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R2, R3, R7, R8 under assorted plain-field writes.
    for (int i = 0; i < 8; i++) begin
      step(1'b1, VEC[i][64:33], 7'h00);
      check($sformatf("R2/R3/R8 vector %0d", i), VEC[i][32:1], VEC[i][0]);
    end

    // R5: enable channel 0 and master, then complete it.
    step(1'b1, 32'h0081_0000, 7'h00);
    check("R2 enable ch0", 32'h0081_0000, 1'b0);
    step(1'b0, 32'h0, 7'h01);
    check("R5/R7 flag set raises sum", 32'h8181_0000, 1'b1);
    idle_check("R8 pulse one cycle", 32'h8181_0000);
    // R5: a pulse on a disabled channel does nothing.
    step(1'b0, 32'h0, 7'h02);
    check("R5 disabled channel ignored", 32'h8181_0000, 1'b0);
    // R4/R9: writing 0 to the flag keeps it.
    step(1'b1, 32'h0081_0000, 7'h00);
    check("R4 zero keeps flag", 32'h8181_0000, 1'b0);
    // R4: writing 1 clears it.
    step(1'b1, 32'h0181_0000, 7'h00);
    check("R4 one clears flag", 32'h0081_0000, 1'b0);
    // R8: a fresh rise gives a fresh pulse.
    step(1'b0, 32'h0, 7'h01);
    check("R8 second rise", 32'h8181_0000, 1'b1);
    // R6: set wins over clear in the same cycle; sum stays high, no pulse.
    step(1'b1, 32'h0181_0000, 7'h01);
    check("R6 set beats clear", 32'h8181_0000, 1'b0);
    // R7: dropping master enable with a flag held drops the sum.
    step(1'b1, 32'h0001_0000, 7'h00);
    check("R7 master enable off", 32'h0101_0000, 1'b0);
    step(1'b1, 32'h0081_0000, 7'h00);
    check("R7/R8 master enable on", 32'h8181_0000, 1'b1);
    // Highest channel, all enables.
    step(1'b1, 32'h7FFF_0000, 7'h00);
    check("R4 clear all, enable all", 32'h00FF_0000, 1'b0);
    step(1'b0, 32'h0, 7'h40);
    check("R5 channel 6 flag", 32'hC0FF_0000, 1'b1);
    idle_check("R8 pulse ends ch6", 32'hC0FF_0000);
    // R9: a write cannot set flags.
    step(1'b1, 32'h7F00_0000, 7'h00);
    check("R9 flags cleared", 32'h0000_0000, 1'b0);
    step(1'b1, 32'h7F00_0000, 7'h00);
    check("R9 write does not set", 32'h0000_0000, 1'b0);
    // R1: reset mid-run.
    step(1'b1, 32'h0000_8000, 7'h00);
    check("R7 force bit", 32'h8000_8000, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", 32'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule